// File: doc/BRIEF.md
# SPI Transfer Queue Front End

This block is the bus-facing control for an SPI master whose data register is double-buffered. A bus write to the data location hands a transfer word to the shift engine. If the engine is already busy, the word is parked in a one-entry holding buffer instead. The write is acknowledged as soon as the word is taken, either by the engine or by the buffer. It is not held until the serial transfer ends. A parked word goes to the engine in the same cycle as the running transfer's done pulse. Chip select therefore stays asserted across the whole chain.

The shift engine and the serial clock generator sit outside this block. The block gives the engine a one-cycle start strobe together with the word to shift. It takes back a one-cycle done pulse and the received word. The received word is latched and can be read at the data location. The status location gives two read-only bits: one shows that chip select is asserted, the other shows that a word is waiting in the holding buffer.

The controller has two states. IDLE has chip select released. RUN has chip select asserted and a transfer in the engine. Its transitions are:
- launch: IDLE to RUN, taken when a data write is accepted.
- shift: RUN to RUN, taken when no done pulse arrives.
- chain: RUN to RUN, taken when done coincides with a parked word or an accepted write.
- release: RUN to IDLE, taken on a done pulse that has nothing queued behind it.

Top module: `spiq_front`

## Requirements
- R1: After reset, chip select is deasserted, both status bits read 0, and the data location reads 0.
- R2: In IDLE, a data write (bus_sel = 0) is acknowledged in the same cycle and raises eng_start in that cycle with eng_wdata equal to bus_wdata. Chip select is asserted from the next cycle.
- R3: In RUN with the holding buffer empty, a data write is acknowledged in the same cycle and does not start the engine. From the next cycle the status pending bit reads 1.
- R4: In RUN with the holding buffer full and no done pulse, a data write is not acknowledged.
- R5: In RUN, a done pulse with a parked word raises eng_start in the same cycle with eng_wdata equal to the parked word. Chip select stays asserted (chain).
- R6: In RUN, a done pulse with nothing parked and no data write in that cycle deasserts chip select from the next cycle (release).
- R7: In RUN, a data write in the same cycle as a done pulse with the buffer empty is acknowledged. It starts the engine with bus_wdata and keeps chip select asserted.
- R8: Every read is acknowledged in the cycle it is requested. A read of the status location (bus_sel = 1) returns the active bit in bit 0, the pending bit in bit 1, and zeros elsewhere.
- R9: On each done pulse, eng_rdata is captured. Reads of the data location return that word from the next cycle until the next done pulse.
- R10: A write to the status location is acknowledged in the same cycle and has no effect on chip select, the buffer or the engine.
- R11: A data write in the same cycle as a done pulse while a word is parked is acknowledged. The parked word goes to the engine, the new word takes its place, and pending stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = data location, 1 = status location |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Request completes this cycle |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack on a read |
| eng_start | output | 1 | One-cycle strobe that loads the engine |
| eng_wdata | output | DATA_W | Word to shift, valid with eng_start |
| eng_done | input | 1 | Engine finished the current transfer |
| eng_rdata | input | DATA_W | Received word, valid with eng_done |
| cs_active | output | 1 | Chip select asserted (logical level) |

## Verification
A pending flag that is wrongly set or cleared has visible effects at the ports. Within one cycle, a data write stalls when it should be taken, or is taken while the buffer is still occupied. On the next done pulse, a lost or stale word shows up on eng_wdata. A controller stuck in the wrong state shows as a chip select level that disagrees with the expected one, one cycle after the launch or release event. A wrong capture register is exposed by the first data read that follows a done pulse. All short sequences of bus operations and done pulses are applied from reset, so each of these faults is met within four cycles of its cause.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    localparam int STAT_ACT_BIT  = 0;
    localparam int STAT_PEND_BIT = 1;

endpackage

// File: rtl/spiq_fsm.sv
module spiq_fsm
    import spiq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    input  logic done_i,
    input  logic pend_i,
    output logic cs_o,
    output logic start_o,
    output logic hand_o,
    output logic park_o
);

    sq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (wr_fire) state_d = SQ_RUN;
            SQ_RUN:  if (done_i && !pend_i && !wr_fire) state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        cs_o    = 1'b0;
        start_o = 1'b0;
        hand_o  = 1'b0;
        park_o  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                start_o = wr_fire;
            end
            SQ_RUN: begin
                cs_o = 1'b1;
                if (done_i) begin
                    start_o = pend_i || wr_fire;
                    hand_o  = pend_i;
                    park_o  = pend_i && wr_fire;
                end else begin
                    park_o  = wr_fire;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spiq_holdbuf.sv
module spiq_holdbuf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_i,
    input  logic              hand_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            data_o <= '0;
        end else begin
            if (park_i) begin
                pend_o <= 1'b1;
                data_o <= wdata_i;
            end else if (hand_i) begin
                pend_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spiq_capture.sv
module spiq_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (take_i) q_o <= data_i;
    end

endmodule

// File: rtl/spiq_front.sv
module spiq_front
    import spiq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              cs_active
);

    logic              pend_q;
    logic [DATA_W-1:0] buf_q;
    logic [DATA_W-1:0] rd_q;
    logic              data_wr, room, wr_fire, done_run;
    logic              hand, park;
    logic [DATA_W-1:0] stat_word;

    assign data_wr  = bus_req && bus_we && (bus_sel == SEL_DATA);
    assign done_run = eng_done && cs_active;
    assign room     = !pend_q || done_run;
    assign wr_fire  = data_wr && room;
    assign bus_ack  = bus_req && (!bus_we || (bus_sel == SEL_STAT) || room);

    spiq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .done_i  (eng_done),
        .pend_i  (pend_q),
        .cs_o    (cs_active),
        .start_o (eng_start),
        .hand_o  (hand),
        .park_o  (park)
    );

    spiq_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .park_i  (park),
        .hand_i  (hand),
        .wdata_i (bus_wdata),
        .pend_o  (pend_q),
        .data_o  (buf_q)
    );

    spiq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (done_run),
        .data_i (eng_rdata),
        .q_o    (rd_q)
    );

    assign eng_wdata = pend_q ? buf_q : bus_wdata;

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_ACT_BIT]  = cs_active;
        stat_word[STAT_PEND_BIT] = pend_q;
    end

    assign bus_rdata = (bus_sel == SEL_STAT) ? stat_word : rd_q;

endmodule

// File: rtl/spiq_front_chk.sv
module spiq_front_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_sel,
    input logic              bus_ack,
    input logic              eng_start,
    input logic              eng_done,
    input logic [DATA_W-1:0] eng_rdata,
    input logic              cs_active,
    input logic              pend,
    input logic [DATA_W-1:0] rd_q
);

    // R8
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> bus_ack);

    // R4
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && !bus_sel && pend && !eng_done |-> !bus_ack);

    // R1
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !pend);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active && eng_done && !pend && !(bus_req && bus_we && !bus_sel)
        |=> !cs_active);

    // R5
    chain_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active && eng_done && pend |=> cs_active);

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active && eng_done |=> rd_q == $past(eng_rdata));

    // R10
    stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_sel && !cs_active |-> !eng_start);

endmodule

bind spiq_front spiq_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_ack   (bus_ack),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata),
    .cs_active (cs_active),
    .pend      (pend_q),
    .rd_q      (rd_q)
);

// File: tb/spiq_front_tb.sv
module spiq_front_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0, bus_we = 1'b0, bus_sel = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_ack;
    logic [W-1:0] bus_rdata;
    logic         eng_start;
    logic [W-1:0] eng_wdata;
    logic         eng_done = 1'b0;
    logic [W-1:0] eng_rdata = '0;
    logic         cs_active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic         m_cs, m_pend;
    logic [W-1:0] m_buf, m_rd;

    always #2.5 clk = ~clk;

    spiq_front #(.DATA_W(W)) u_dut (.*);

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_req = 1'b0; eng_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cs = 1'b0; m_pend = 1'b0; m_buf = '0; m_rd = '0;
    endtask

    // code: 0 none, 1 data write, 2 status write, 3 data read, 4 status read; +5 adds done
    task automatic step(input int code, input logic [W-1:0] wd, input logic [W-1:0] rd);
        logic done, req, we, sel, fire, exp_ack, exp_start;
        logic [W-1:0] exp_wd, exp_rd;
        int k;
        string t;
        @(negedge clk);
        k    = code % 5;
        done = (code >= 5) && m_cs;
        req  = (k != 0);
        we   = (k == 1) || (k == 2);
        sel  = (k == 2) || (k == 4);
        bus_req = req; bus_we = we; bus_sel = sel; bus_wdata = wd;
        eng_done = done; eng_rdata = rd;
        #1;
        exp_ack   = req && (!we || sel || !m_pend || done);
        fire      = req && we && !sel && exp_ack;
        exp_start = m_cs ? (done && (m_pend || fire)) : fire;
        exp_wd    = m_pend ? m_buf : wd;

        chk(m_cs ? "R6 cs level" : "R2 cs level", W'(cs_active), W'(m_cs));
        if (req) begin
            if (!we)          t = "R8 read ack";
            else if (sel)     t = "R10 status write ack";
            else if (!m_cs)   t = "R2 idle write ack";
            else if (done)    t = m_pend ? "R11 write ack on done" : "R7 write ack on done";
            else              t = m_pend ? "R4 stall" : "R3 park ack";
            chk(t, W'(bus_ack), W'(exp_ack));
        end
        if (!m_cs)       t = sel ? "R10 no start" : "R2 start";
        else if (m_pend) t = "R5 chain start";
        else             t = "R7 chain start";
        chk(t, W'(eng_start), W'(exp_start));
        if (exp_start)
            chk(m_pend ? "R5 buffered word" : "R7 bypass word", eng_wdata, exp_wd);
        if (req && !we) begin
            if (sel) begin
                exp_rd = '0;
                exp_rd[0] = m_cs;
                exp_rd[1] = m_pend;
                chk("R8 status read", bus_rdata, exp_rd);
            end else begin
                chk("R9 data read", bus_rdata, m_rd);
            end
        end

        if (done) m_rd = rd;
        if (!m_cs) begin
            if (fire) m_cs = 1'b1;
        end else if (done) begin
            if (m_pend) begin
                if (fire) m_buf = wd;
                else      m_pend = 1'b0;
            end else if (!fire) begin
                m_cs = 1'b0;
            end
        end else if (fire) begin
            m_pend = 1'b1;
            m_buf  = wd;
        end
        @(posedge clk);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1 cs after reset", W'(cs_active), '0);
        bus_req = 1'b1; bus_we = 1'b0; bus_sel = 1'b1;
        #1;
        chk("R1 status after reset", bus_rdata, '0);
        bus_sel = 1'b0;
        #1;
        chk("R1 data after reset", bus_rdata, '0);
        bus_req = 1'b0;

        for (int s = 0; s < 10000; s++) begin
            int c;
            c = s;
            do_reset();
            for (int j = 0; j < 4; j++) begin
                step(c % 10, W'(s * 7 + j * 29 + 3), W'(s * 13 + j * 5 + 101));
                c = c / 10;
            end
        end
        @(negedge clk);
        bus_req = 1'b0; eng_done = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #950000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule